// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small register whose behaviour on each rising clock edge is chosen by a two-bit mode select. It can take a full word in parallel, move its contents one place toward bit 0, move them one place toward the top bit, or keep them unchanged. Two serial inputs feed the vacated end in the shift modes. The one on the low side enters bit 0 when data moves upward. The one on the high side enters the top bit when data moves downward.

The register contents are driven straight onto the parallel output at all times. Any end bit can therefore serve as the serial output while the whole word is also visible. The mode select acts only on the next-state multiplexing and never touches the clock. An active-high synchronous reset clears the word for test convenience. The width is a parameter and defaults to 4.

Top module: `usr_shift4`

## Requirements
- R1: When `rst` is high at a rising edge, `reg_out` becomes all zeros on that edge, whatever `mode_sel` and the data inputs are.
- R2: With `mode_sel` = 2'b00 (parallel load), each `reg_out[i]` takes `par_in[i]` on the edge.
- R3: With `mode_sel` = 2'b01 (shift toward bit 0), `reg_out[i]` takes `reg_out[i+1]`, and the top bit takes `ser_hi_in`.
- R4: With `mode_sel` = 2'b10 (shift toward the top bit), `reg_out[0]` takes `ser_lo_in`, and `reg_out[i]` takes `reg_out[i-1]`.
- R5: With `mode_sel` = 2'b11 (hold), `reg_out` keeps its value across the edge.
- R6: Mode and data inputs are sampled only at the rising edge. `reg_out` does not change between edges, whatever the inputs do.
- R7: A single 1 loaded into bit 0 and followed by upward shifts with `ser_lo_in` = 0 visits bits 1, 2 and 3 in turn and is gone after the fourth shift. The mirror case also holds: a 1 in bit 3, shifted downward with `ser_hi_in` = 0, reaches bit 0 and is gone after the fourth shift.
- R8: Inputs that the current mode does not select have no effect. `ser_hi_in` has no effect when shifting up. `ser_lo_in` has no effect when shifting down. Neither serial input has an effect in load mode, and `par_in` has no effect outside load mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, overrides every mode |
| mode_sel | input | 2 | 00 load, 01 shift toward bit 0, 10 shift toward top, 11 hold |
| par_in | input | WIDTH | Parallel load word |
| ser_lo_in | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_hi_in | input | 1 | Serial bit entering the top bit on a downward shift |
| reg_out | output | WIDTH | Current register contents |

## Verification
The bench sweeps every starting word, every mode, every parallel word and every serial pair against an arithmetic next-state model. This catches a swapped mode encoding, which would load when asked to hold or shift the wrong way, and a serial input wired to the wrong end, which would inject bits into the far side of the word. Walking-one runs in both directions expose an off-by-one neighbour connection, which would leave the bit stuck or make it skip a position. Reset is applied together with a load to confirm that it wins. A long random mode sequence checks that no state leaks between operations.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UP   = 2'b10,
    MODE_HOLD = 2'b11
  } usr_mode_e;

  localparam int unsigned NUM_MODES = 4;
endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic [1:0]           mode_sel,
  output logic [NUM_MODES-1:0] mode_hot
);
  always_comb begin
    mode_hot = '0;
    for (int k = 0; k < NUM_MODES; k++) begin
      if (mode_sel == k[1:0]) mode_hot[k] = 1'b1;
    end
  end
endmodule

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
  import usr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_MODES-1:0] mode_hot,
  input  logic                 par_bit,
  input  logic                 from_lower,
  input  logic                 from_upper,
  output logic                 bit_q
);
  logic nxt;

  always_comb begin
    nxt = bit_q;
    if (mode_hot[MODE_LOAD]) nxt = par_bit;
    if (mode_hot[MODE_DOWN]) nxt = from_upper;
    if (mode_hot[MODE_UP])   nxt = from_lower;
  end

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= nxt;
  end
endmodule

// File: rtl/usr_shift4.sv
module usr_shift4
  import usr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_lo_in,
  input  logic             ser_hi_in,
  output logic [WIDTH-1:0] reg_out
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [NUM_MODES-1:0] mode_hot;
  logic [WIDTH-1:0]     lower_src;
  logic [WIDTH-1:0]     upper_src;

  usr_mode_decode u_dec (
    .mode_sel (mode_sel),
    .mode_hot (mode_hot)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lo_end
      assign lower_src[i] = ser_lo_in;
    end else begin : g_lo_mid
      assign lower_src[i] = reg_out[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign upper_src[i] = ser_hi_in;
    end else begin : g_hi_mid
      assign upper_src[i] = reg_out[i+1];
    end

    usr_bit_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .mode_hot   (mode_hot),
      .par_bit    (par_in[i]),
      .from_lower (lower_src[i]),
      .from_upper (upper_src[i]),
      .bit_q      (reg_out[i])
    );
  end
endmodule

// File: rtl/usr_shift4_chk.sv
module usr_shift4_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_lo_in,
  input logic             ser_hi_in,
  input logic [WIDTH-1:0] reg_out
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> reg_out == '0); // R1

  AST_LOAD_TAKES_PAR: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b00 |=> reg_out == $past(par_in)); // R2

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b01 |=> reg_out == {$past(ser_hi_in), $past(reg_out[WIDTH-1:1])}); // R3

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b10 |=> reg_out == {$past(reg_out[WIDTH-2:0]), $past(ser_lo_in)}); // R4

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b11 |=> $stable(reg_out)); // R5
endmodule

bind usr_shift4 usr_shift4_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_sel  (mode_sel),
  .par_in    (par_in),
  .ser_lo_in (ser_lo_in),
  .ser_hi_in (ser_hi_in),
  .reg_out   (reg_out)
);

// File: tb/usr_shift4_bench.sv
module usr_shift4_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_sel = 2'b11;
  logic [W-1:0] par_in = '0;
  logic         ser_lo_in = 1'b0;
  logic         ser_hi_in = 1'b0;
  logic [W-1:0] reg_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  usr_shift4 #(.WIDTH(W)) u_usr_shift4 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .par_in(par_in),
    .ser_lo_in(ser_lo_in), .ser_hi_in(ser_hi_in), .reg_out(reg_out)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic [1:0] m,
                                         input logic [W-1:0] p, input logic lo, input logic hi);
    case (m)
      2'b00:   return p;
      2'b01:   return {hi, cur[W-1:1]};
      2'b10:   return {cur[W-2:0], lo};
      default: return cur;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] p, input logic lo, input logic hi);
    @(negedge clk);
    mode_sel = m; par_in = p; ser_lo_in = lo; ser_hi_in = hi;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [W-1:0] exp;
    logic [W-1:0] snap;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", reg_out, '0);
    @(negedge clk); rst = 1'b0;

    // R1: reset beats a load
    step(2'b00, 4'b1111, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    step(2'b00, 4'b1010, 1'b1, 1'b1);
    check("R1 reset over load", reg_out, '0);
    @(negedge clk); rst = 1'b0;

    // R2-R5, R8: exhaustive sweep
    for (int st = 0; st < 16; st++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 16; p++)
          for (int s = 0; s < 4; s++) begin
            step(2'b00, st[W-1:0], 1'b0, 1'b0);
            exp = model(st[W-1:0], m[1:0], p[W-1:0], s[0], s[1]);
            step(m[1:0], p[W-1:0], s[0], s[1]);
            case (m)
              0:       check("R2 load sweep", reg_out, exp);
              1:       check("R3 shift down sweep", reg_out, exp);
              2:       check("R4 shift up sweep", reg_out, exp);
              default: check("R5 hold sweep", reg_out, exp);
            endcase
          end

    // R8: an unselected serial input is ignored
    step(2'b00, 4'b0110, 1'b0, 1'b0);
    step(2'b10, 4'b1111, 1'b0, 1'b1);
    check("R8 hi serial ignored on up shift", reg_out, 4'b1100);
    step(2'b01, 4'b1111, 1'b1, 1'b0);
    check("R8 lo serial ignored on down shift", reg_out, 4'b0110);
    step(2'b00, 4'b0000, 1'b1, 1'b1);
    check("R8 serial ignored on load", reg_out, 4'b0000);

    // R7: walking one, upward
    step(2'b00, 4'b0001, 1'b0, 1'b0);
    for (int k = 1; k <= W; k++) begin
      step(2'b10, 4'b1111, 1'b0, 1'b1);
      check("R7 walk up", reg_out, (k < W) ? (4'b0001 << k) : 4'b0000);
    end
    // R7: walking one, downward
    step(2'b00, 4'b1000, 1'b0, 1'b0);
    for (int k = 1; k <= W; k++) begin
      step(2'b01, 4'b1111, 1'b1, 1'b0);
      check("R7 walk down", reg_out, (k < W) ? (4'b1000 >> k) : 4'b0000);
    end

    // R6: inputs toggling between edges do not move the output
    step(2'b00, 4'b1001, 1'b0, 1'b0);
    @(negedge clk);
    snap = reg_out;
    mode_sel = 2'b00; par_in = 4'b0110; #1;
    mode_sel = 2'b10; ser_lo_in = 1'b1; #1;
    mode_sel = 2'b01; ser_hi_in = 1'b1; #1;
    check("R6 no change between edges", reg_out, snap);
    mode_sel = 2'b11;
    @(posedge clk); #1;
    check("R6 last value at edge wins", reg_out, 4'b1001);

    // R2-R5: random mode sequence against the model
    exp = reg_out;
    for (int k = 0; k < 600; k++) begin
      logic [1:0]   m  = 2'($urandom);
      logic [W-1:0] p  = W'($urandom);
      logic         lo = 1'($urandom);
      logic         hi = 1'($urandom);
      exp = model(exp, m, p, lo, hi);
      step(m, p, lo, hi);
      check("R2-R5 random sequence", reg_out, exp);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule